// File: doc/BRIEF.md
# Adaptive Sample-Domain Equalizer with Error Back-Mapping

This block is a transversal (FIR) equalizer whose taps adapt by least mean squares. It runs on samples taken by a free-running clock slightly faster than the symbol rate, so it sits ahead of the timing interpolator. Samples arrive on a valid/ready stream and equalized samples leave on another. `s_ready` is high whenever the output register is empty or is being drained this cycle. A sample is accepted only on a cycle where `s_valid` and `s_ready` are both high. While `m_valid` is high and `m_ready` is low, the output word is held and no new sample is taken.

The error that drives adaptation comes from the symbol domain: it is the interpolated sample minus the target output. The block therefore maps it back onto the sample grid with a two-point linear blend. The blend uses the current error, the previous error and the loop's fractional phase. A linear blend is accurate enough because the adaptation only needs the error's direction on average. Taps change only while the acquisition control is high. During tracking they stay frozen.

Samples and errors are two's complement fractions with (width − 1) fraction bits. Each tap has a (CW + 8)-bit accumulator, whose upper CW bits are the coefficient, and the coefficient has CW − 2 fraction bits. The step size is a right shift of 7, which is about 0.0078 and so close to a step of 0.01.

Top module: `lms_async_eq`

## Requirements
- R1: Reset clears the delay line, deasserts `m_valid`, and loads every tap accumulator with zero except the centre tap (index TAPS/2), which holds unity (2^(ACCW−2)). Right after reset the output is therefore the input delayed by TAPS/2 accepted samples.
- R2: On each accepted sample the delay line shifts, with the new sample at index 0. The next `m_data` equals the sum over i of coef[i]·x[i], arithmetically shifted right by CW−2 and saturated to the DW-bit range. It appears one cycle after acceptance.
- R3: `s_ready` = !m_valid || m_ready. `m_valid` rises on the cycle after an acceptance. While `m_valid` is high and `m_ready` is low, `m_data` and `m_valid` hold.
- R4: On an error strobe the back-mapped error is floor(((2^PW − p)·e + p·e_prev) / 2^PW), where p is the unsigned PW-bit `err_phase` and e_prev is the error from the previous strobe.
- R5: On an error strobe with `acq` high, every accumulator gains floor(e_back·x[i] / 2^7). Here x[i] is the delay line before any shift in that cycle. With no strobe, no tap changes.
- R6: With `acq` low, error strobes leave every tap unchanged.
- R7: An accumulator that would leave its signed ACCW-bit range saturates to the nearest limit and does not wrap.
- R8: e_prev is updated on every error strobe, including strobes that arrive while `acq` is low.
- R9: An FIR sum beyond the DW-bit range gives 2^(DW−1)−1 or −2^(DW−1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | DW | Asynchronous-grid sample, signed |
| m_valid | output | 1 | Equalized sample valid |
| m_ready | input | 1 | Downstream can take the output |
| m_data | output | DW | Equalized sample, signed |
| err_valid | input | 1 | Symbol-domain error strobe |
| err_data | input | EW | Symbol-domain error, signed |
| err_phase | input | PW | Fractional phase, already scaled by Ts/T |
| acq | input | 1 | High: adaptation on (acquisition); low: taps frozen |

## Verification
Tap state is hidden, so every fault in it shows up on the very next equalized sample as a wrong weighted sum. A wrong reset value shows on the first output that reaches the centre delay. A missed update or an update while frozen shows on the first sample accepted after the strobe. Accumulator wraparound instead of saturation shows as an impulse response with the wrong sign. A wrong back-mapped error or a stale previous error shifts all taps at once, and the next sample exposes the shift.

// File: rtl/lms_eq_pkg.sv
package lms_eq_pkg;
  localparam int EQ_TAPS_DEF  = 7;
  localparam int EQ_DW_DEF    = 12;
  localparam int EQ_EW_DEF    = 12;
  localparam int EQ_CW_DEF    = 16;
  localparam int EQ_PW_DEF    = 6;
  localparam int EQ_MU_SH_DEF = 7;
endpackage

// File: rtl/lms_eq_tapline.sv
module lms_eq_tapline #(
  parameter int TAPS = 7,
  parameter int DW   = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic signed [DW-1:0] din,
  output logic signed [DW-1:0] line_q   [TAPS],
  output logic signed [DW-1:0] line_nxt [TAPS]
);
  always_comb begin
    line_nxt[0] = din;
    for (int i = 1; i < TAPS; i++) line_nxt[i] = line_q[i-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) line_q[i] <= '0;
    end else if (shift_en) begin
      line_q <= line_nxt;
    end
  end
endmodule

// File: rtl/lms_eq_backmap.sv
module lms_eq_backmap #(
  parameter int EW = 12,
  parameter int PW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 err_valid,
  input  logic signed [EW-1:0] err_cur,
  input  logic        [PW-1:0] phase,
  output logic signed [EW-1:0] e_back,
  output logic signed [EW-1:0] e_prev
);
  logic signed [PW+1:0]    w_cur, w_prev;
  logic signed [EW+PW+1:0] mix;

  // R4: two-point linear blend onto the sample grid
  always_comb begin
    w_prev = $signed({2'b00, phase});
    w_cur  = $signed({2'b01, {PW{1'b0}}}) - w_prev;
    mix    = w_cur * err_cur + w_prev * e_prev;
    e_back = EW'(mix >>> PW);
  end

  // R8: previous error tracks every strobe
  always_ff @(posedge clk) begin
    if (!rst_n)         e_prev <= '0;
    else if (err_valid) e_prev <= err_cur;
  end
endmodule

// File: rtl/lms_eq_coef.sv
module lms_eq_coef #(
  parameter int   DW       = 12,
  parameter int   EW       = 12,
  parameter int   CW       = 16,
  parameter int   MU_SHIFT = 7,
  parameter logic IS_UNITY = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd_en,
  input  logic signed [EW-1:0] e_back,
  input  logic signed [DW-1:0] x_tap,
  output logic signed [CW-1:0] coef
);
  localparam int ACCW  = DW + EW;
  localparam int GUARD = ACCW - CW;
  localparam logic signed [ACCW-1:0] RST_VAL =
    IS_UNITY ? (ACCW'(1) <<< (ACCW - 2)) : '0;
  localparam logic [ACCW-1:0] SAT_HI = {1'b0, {(ACCW-1){1'b1}}};
  localparam logic [ACCW-1:0] SAT_LO = {1'b1, {(ACCW-1){1'b0}}};

  logic signed [ACCW-1:0] acc, prod, delta;
  logic        [ACCW:0]   sum;

  always_comb begin
    prod  = e_back * x_tap;
    delta = prod >>> MU_SHIFT;               // R5: step 2^-MU_SHIFT
    sum   = {acc[ACCW-1], acc} + {delta[ACCW-1], delta};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= RST_VAL;              // R1
    else if (upd_en) begin
      if (sum[ACCW] != sum[ACCW-1])          // R7: clamp instead of wrap
        acc <= sum[ACCW] ? SAT_LO : SAT_HI;
      else
        acc <= sum[ACCW-1:0];
    end
  end

  assign coef = acc[ACCW-1:GUARD];
endmodule

// File: rtl/lms_eq_fir.sv
module lms_eq_fir #(
  parameter int TAPS = 7,
  parameter int DW   = 12,
  parameter int CW   = 16
) (
  input  logic signed [CW-1:0] coef [TAPS],
  input  logic signed [DW-1:0] x    [TAPS],
  output logic signed [DW-1:0] y
);
  localparam int FRAC = CW - 2;
  localparam int SW   = CW + DW + $clog2(TAPS) + 1;

  logic signed [SW-1:0] total, shifted;

  always_comb begin
    total = '0;
    for (int i = 0; i < TAPS; i++) total = total + coef[i] * x[i];
    shifted = total >>> FRAC;
    // R9: clip to output width
    if (shifted[SW-1:DW-1] == '0 || shifted[SW-1:DW-1] == '1)
      y = shifted[DW-1:0];
    else if (shifted[SW-1])
      y = {1'b1, {(DW-1){1'b0}}};
    else
      y = {1'b0, {(DW-1){1'b1}}};
  end
endmodule

// File: rtl/lms_async_eq.sv
module lms_async_eq
  import lms_eq_pkg::*;
#(
  parameter int TAPS     = EQ_TAPS_DEF,
  parameter int DW       = EQ_DW_DEF,
  parameter int EW       = EQ_EW_DEF,
  parameter int CW       = EQ_CW_DEF,
  parameter int PW       = EQ_PW_DEF,
  parameter int MU_SHIFT = EQ_MU_SH_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_data,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic signed [DW-1:0] m_data,
  input  logic                 err_valid,
  input  logic signed [EW-1:0] err_data,
  input  logic        [PW-1:0] err_phase,
  input  logic                 acq
);
  localparam int CENTRE = TAPS / 2;

  logic                 take, upd;
  logic signed [DW-1:0] line_q   [TAPS];
  logic signed [DW-1:0] line_nxt [TAPS];
  logic signed [CW-1:0] coef     [TAPS];
  logic [TAPS*CW-1:0]   coef_bus;
  logic signed [EW-1:0] e_back, e_prev;
  logic signed [DW-1:0] fir_y;

  assign s_ready = !m_valid || m_ready;      // R3
  assign take    = s_valid && s_ready;
  assign upd     = err_valid && acq;         // R5, R6

  lms_eq_tapline #(.TAPS(TAPS), .DW(DW)) u_line (
    .clk(clk), .rst_n(rst_n), .shift_en(take), .din(s_data),
    .line_q(line_q), .line_nxt(line_nxt)
  );

  lms_eq_backmap #(.EW(EW), .PW(PW)) u_bmap (
    .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_cur(err_data),
    .phase(err_phase), .e_back(e_back), .e_prev(e_prev)
  );

  for (genvar g = 0; g < TAPS; g++) begin : g_tap
    lms_eq_coef #(
      .DW(DW), .EW(EW), .CW(CW), .MU_SHIFT(MU_SHIFT),
      .IS_UNITY(g == CENTRE)
    ) u_coef (
      .clk(clk), .rst_n(rst_n), .upd_en(upd), .e_back(e_back),
      .x_tap(line_q[g]), .coef(coef[g])
    );
    assign coef_bus[g*CW +: CW] = coef[g];
  end

  lms_eq_fir #(.TAPS(TAPS), .DW(DW), .CW(CW)) u_fir (
    .coef(coef), .x(line_nxt), .y(fir_y)
  );

  // R2: registered output stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else begin
      if (take) begin
        m_valid <= 1'b1;
        m_data  <= fir_y;
      end else if (m_ready) begin
        m_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lms_async_eq_chk.sv
module lms_async_eq_chk #(
  parameter int TAPS = 7,
  parameter int DW   = 12,
  parameter int EW   = 12,
  parameter int CW   = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 s_valid,
  input logic                 s_ready,
  input logic                 m_valid,
  input logic                 m_ready,
  input logic signed [DW-1:0] m_data,
  input logic                 err_valid,
  input logic signed [EW-1:0] err_data,
  input logic                 acq,
  input logic signed [EW-1:0] e_back,
  input logic signed [EW-1:0] e_prev,
  input logic [TAPS*CW-1:0]   coef_bus
);
  AST_ACCEPT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid && s_ready |=> m_valid);                                    // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data));                // R3
  AST_FROZEN_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
    !acq |=> $stable(coef_bus));                                        // R6
  AST_IDLE_TAPS: assert property (@(posedge clk) disable iff (!rst_n)
    !err_valid |=> $stable(coef_bus));                                  // R5
  AST_BACKMAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ((e_back >= err_data) || (e_back >= e_prev)) &&
    ((e_back <= err_data) || (e_back <= e_prev)));                      // R4
  AST_PREV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> e_prev == $past(err_data));                           // R8
endmodule

bind lms_async_eq lms_async_eq_chk #(
  .TAPS(TAPS), .DW(DW), .EW(EW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
  .err_valid(err_valid), .err_data(err_data), .acq(acq),
  .e_back(e_back), .e_prev(e_prev), .coef_bus(coef_bus)
);

// File: tb/lms_async_eq_test.sv
module lms_async_eq_test;
  localparam int TAPS = 7, DW = 12, EW = 12, CW = 16, PW = 6, MU = 7;
  localparam int ACCW = DW + EW, GUARD = ACCW - CW, FRAC = CW - 2;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, m_ready = 1, err_valid = 0, acq = 0;
  logic signed [DW-1:0] s_data = '0;
  logic signed [EW-1:0] err_data = '0;
  logic [PW-1:0] err_phase = '0;
  logic s_ready, m_valid;
  logic signed [DW-1:0] m_data;

  lms_async_eq uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .err_valid(err_valid), .err_data(err_data), .err_phase(err_phase),
    .acq(acq)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0, bp_on = 0;
  int   exp_q[$];
  string tag_q[$];
  longint acc_m[TAPS];
  longint line_m[TAPS];
  longint eprev_m = 0;

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: models one accepted sample and queues the expected output
  task automatic send(int x, string tag);
    longint tot, sh;
    for (int i = TAPS - 1; i > 0; i--) line_m[i] = line_m[i-1];
    line_m[0] = x;
    tot = 0;
    for (int i = 0; i < TAPS; i++) tot += (acc_m[i] >>> GUARD) * line_m[i];
    sh = tot >>> FRAC;
    if (sh > 2047) sh = 2047;
    if (sh < -2048) sh = -2048;
    exp_q.push_back(int'(sh));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    s_valid = 1; s_data = DW'(x);
    forever begin
      @(negedge clk);
      if (s_ready) break;
    end
    @(posedge clk); #1;
    s_valid = 0;
  endtask

  task automatic err(int e, int ph);
    longint eb, d;
    eb = ((64 - ph) * longint'(e) + ph * eprev_m) >>> PW;
    if (acq) begin
      for (int i = 0; i < TAPS; i++) begin
        d = (eb * line_m[i]) >>> MU;
        acc_m[i] += d;
        if (acc_m[i] > 64'sd8388607)  acc_m[i] = 64'sd8388607;
        if (acc_m[i] < -64'sd8388608) acc_m[i] = -64'sd8388608;
      end
    end
    eprev_m = e;
    @(posedge clk); #1;
    err_valid = 1; err_data = EW'(e); err_phase = PW'(ph);
    @(posedge clk); #1;
    err_valid = 0;
  endtask

  // back-pressure generator
  always @(posedge clk) begin
    #1;
    m_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  logic signed [DW-1:0] held;
  bit hold_f = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (hold_f && m_valid) begin
        check("R3 stall hold", m_data, held);
      end
      hold_f = 0;
      if (m_valid && !m_ready) begin
        check("R3 no accept while stalled", s_ready, 0);
        held = m_data; hold_f = 1;
      end
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) check("R2 unexpected output", 1, 0);
        else check(tag_q.pop_front(), m_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end

  initial begin
    for (int i = 0; i < TAPS; i++) begin acc_m[i] = 0; line_m[i] = 0; end
    acc_m[TAPS/2] = longint'(1) << (ACCW - 2);
    repeat (5) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 m_valid after reset", m_valid, 0);
    check("R3 s_ready after reset", s_ready, 1);
    // R1: pure delay by centre index
    send(100, "R1"); send(200, "R1"); send(300, "R1"); send(400, "R1");
    send(-500, "R1"); send(0, "R1"); send(0, "R1");
    // R3: random back-pressure
    bp_on = 1;
    for (int k = 0; k < 24; k++) send((k * 173) % 1500 - 700, "R3");
    bp_on = 0;
    // R5: adaptation with zero phase
    acq = 1;
    err(300, 0);
    send(50, "R5"); send(-90, "R5");
    err(-700, 0);
    for (int k = 0; k < 5; k++) send(k * 211 - 400, "R5");
    // R4: non-zero phases
    err(-400, 32);
    send(123, "R4");
    err(250, 63);
    send(-77, "R4"); send(600, "R4");
    err(900, 17);
    send(10, "R4");
    // R6: frozen during tracking
    acq = 0;
    err(1000, 0); err(-1500, 40);
    send(333, "R6"); send(-444, "R6"); send(55, "R6");
    // R8: previous error recorded during tracking
    err(1000, 0);
    acq = 1;
    err(0, 63);
    send(-200, "R8"); send(700, "R8");
    // R7/R9: drive accumulators to the positive limit
    for (int k = 0; k < TAPS; k++) send(2047, "R9");
    for (int k = 0; k < 200; k++) err(2047, 0);
    send(2047, "R9"); send(2047, "R9");
    send(64, "R7");
    for (int k = 0; k < TAPS; k++) send(0, "R7");
    // R7: negative limit
    for (int k = 0; k < TAPS; k++) send(-2048, "R9");
    for (int k = 0; k < 300; k++) err(2047, 0);
    send(-2048, "R9");
    send(100, "R7");
    for (int k = 0; k < TAPS; k++) send(0, "R7");
    acq = 0;
    repeat (10) @(posedge clk);
    check("R2 all outputs produced", exp_q.size(), 0);
    done = 1;
    summary();
  end
endmodule